// File: doc/BRIEF.md
# PWM Audio Sample Output

This block turns a stream of unsigned audio samples into one pulse-width-modulated bit. An external RC low-pass filter and a speaker follow it. A sweep counter steps through every code value once per sample period. The output bit stays high while the counter is below the sample being played. Each frame of 256 counter steps therefore carries one sample, and its duty cycle is proportional to that sample.

The counter advances only on cycles where the tick input is high. This lets a fast system clock drive a slower PWM rate. The tick rate must equal the audio sample rate times the code count. For example, an 8 kHz stream at 8-bit depth needs a 2.048 MHz tick.

Upstream logic delivers samples through a valid/ready handshake into a one-entry holding register. The held sample becomes the compare level only when the counter wraps, so a frame is never cut short. A one-cycle request pulse marks each frame boundary. If no sample is waiting at that boundary, the previous level is replayed and a one-cycle underrun pulse is raised.

Top module: `pwm_audio_out`

## Requirements
- R1: After reset is released, `pwm_o`, `req_o` and `underrun_o` are 0, `sample_ready_o` is 1, and the compare level is 0.
- R2: `pwm_o` is 1 exactly while the sweep count is below the compare level. Once it falls within a frame, it stays 0 until the frame ends.
- R3: The sweep count advances by one, modulo 256, on each cycle where `tick_i` is 1, and holds otherwise. A frame therefore lasts exactly 256 ticks.
- R4: A level of 0 gives no high ticks in a frame. A level of 255 gives 255 high ticks followed by one low tick. The output is 0 on the last tick of every frame.
- R5: A sample accepted during a frame has no effect on that frame. It becomes the compare level only at the next wrap.
- R6: `sample_ready_o` is 1 exactly when the holding register is empty. A sample is taken when `sample_valid_i` and `sample_ready_o` are both 1. Samples offered while the register is full are ignored.
- R7: If the holding register is empty at a wrap, the previous level is replayed in the next frame. `underrun_o` is then 1 for one cycle, in the first cycle of that frame.
- R8: `req_o` is 1 for exactly one cycle, the first cycle after each wrap, when the sweep count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sweep clock enable, at sample rate times 256 |
| sample_i | input | 8 | Unsigned audio sample |
| sample_valid_i | input | 1 | Sample present on `sample_i` |
| sample_ready_o | output | 1 | Holding register is empty |
| pwm_o | output | 1 | Pulse-width-modulated output bit |
| req_o | output | 1 | One-cycle pulse at the start of each frame |
| underrun_o | output | 1 | One-cycle pulse when a frame replays the previous level |

## Verification
The following behaviours are checked by properties on every cycle:
- the counter stepping and holding with the tick input;
- the compare level staying frozen between wraps;
- the output staying low once it has fallen within a frame;
- the low final tick;
- the request pulse and its one-cycle width;
- the handshake filling the holding register.

The duty count per frame for a given level, the exact sample that each frame plays, the replay on underrun, and the rejection of samples offered while the register is full all depend on the sequence of upstream traffic. Only the bench's scenarios show these. They run under three tick rates.

// File: rtl/pwm_audio_pkg.sv
package pwm_audio_pkg;
  localparam int unsigned CODE_W_DEF = 8;
endpackage

// File: rtl/pwm_sweep_ctr.sv
module pwm_sweep_ctr #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [CODE_W-1:0] cnt_o,
  output logic              wrap_o
);
  localparam logic [CODE_W-1:0] CntMax = {CODE_W{1'b1}};

  logic [CODE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CODE_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (cnt_q == CntMax);
endmodule

// File: rtl/pwm_sample_buf.sv
module pwm_sample_buf #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] sample_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              wrap_i,
  output logic [CODE_W-1:0] level_o,
  output logic              req_o,
  output logic              underrun_o
);
  logic [CODE_W-1:0] hold_q, level_q;
  logic              full_q, req_q, under_q;
  logic              take;

  assign take = valid_i && !full_q;

  // hold slot: refilled on accept, drained at wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (take) begin
      hold_q <= sample_i;
      full_q <= 1'b1;
    end else if (wrap_i) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                level_q <= '0;
    else if (wrap_i && full_q)  level_q <= hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      under_q <= 1'b0;
    end else begin
      req_q   <= wrap_i;
      under_q <= wrap_i && !full_q;
    end
  end

  assign ready_o    = !full_q;
  assign level_o    = level_q;
  assign req_o      = req_q;
  assign underrun_o = under_q;
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
  parameter int unsigned CODE_W = 8
) (
  input  logic [CODE_W-1:0] cnt_i,
  input  logic [CODE_W-1:0] level_i,
  output logic              pwm_o
);
  assign pwm_o = (cnt_i < level_i);
endmodule

// File: rtl/pwm_audio_out.sv
module pwm_audio_out #(
  parameter int unsigned CODE_W = pwm_audio_pkg::CODE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] sample_i,
  input  logic              sample_valid_i,
  output logic              sample_ready_o,
  output logic              pwm_o,
  output logic              req_o,
  output logic              underrun_o
);
  logic [CODE_W-1:0] cnt_q, level_q;
  logic              wrap;

  pwm_sweep_ctr #(.CODE_W(CODE_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (cnt_q),
    .wrap_o (wrap)
  );

  pwm_sample_buf #(.CODE_W(CODE_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample_i),
    .valid_i    (sample_valid_i),
    .ready_o    (sample_ready_o),
    .wrap_i     (wrap),
    .level_o    (level_q),
    .req_o      (req_o),
    .underrun_o (underrun_o)
  );

  pwm_cmp #(.CODE_W(CODE_W)) u_cmp (
    .cnt_i   (cnt_q),
    .level_i (level_q),
    .pwm_o   (pwm_o)
  );
endmodule

// File: rtl/pwm_audio_out_chk.sv
module pwm_audio_out_chk #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              sample_valid_i,
  input logic              sample_ready_o,
  input logic              pwm_o,
  input logic              req_o,
  input logic              underrun_o,
  input logic [CODE_W-1:0] cnt_i,
  input logic [CODE_W-1:0] level_i
);
  localparam logic [CODE_W-1:0] CntMax = {CODE_W{1'b1}};

  logic wrap_seen;
  assign wrap_seen = tick_i && (cnt_i == CntMax);

  p_cnt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_i));

  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_i == $past(cnt_i) + CODE_W'(1));

  p_stays_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwm_o && !wrap_seen) |=> !pwm_o);

  p_last_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CntMax) |-> !pwm_o);

  p_level_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_seen |=> $stable(level_i));

  p_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && sample_ready_o) |=> !sample_ready_o);

  p_under_in_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> req_o);

  p_req_after_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_seen |=> (req_o && cnt_i == '0));

  p_req_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
endmodule

bind pwm_audio_out pwm_audio_out_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tick_i         (tick_i),
  .sample_valid_i (sample_valid_i),
  .sample_ready_o (sample_ready_o),
  .pwm_o          (pwm_o),
  .req_o          (req_o),
  .underrun_o     (underrun_o),
  .cnt_i          (cnt_q),
  .level_i        (level_q)
);

// File: tb/sim_pwm_audio_out.sv
`timescale 1ns/1ps
module sim_pwm_audio_out;
  localparam int W = 8;

  typedef struct {
    int unsigned lvl;
    bit          under;
  } frame_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic [W-1:0] smp = '0;
  logic         vld = 1'b0;
  logic         rdy, pwm, req, und;

  int total = 0, bad = 0;
  int tick_div = 1, tick_ph = 0;
  int frames_done = 0;
  bit in_frame = 0, finished = 0;
  int hi_cnt = 0, tk_cnt = 0;
  frame_t exp_q[$];
  frame_t cur;
  int unsigned last_lvl = 0;

  always #10 clk = ~clk;

  pwm_audio_out #(.CODE_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sample_i(smp),
    .sample_valid_i(vld), .sample_ready_o(rdy), .pwm_o(pwm),
    .req_o(req), .underrun_o(und)
  );

  task automatic check(input string req_tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req_tag, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
    tick    <= (tick_ph == 0);
  end

  // monitor: one frame per req pulse
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (req) begin
        if (in_frame) begin
          check("R2/R4 high ticks", hi_cnt, int'(cur.lvl));
          check("R3 frame ticks", tk_cnt, 256);
          frames_done++;
        end
        if (exp_q.size() > 0) begin
          cur = exp_q.pop_front();
          check("R7 underrun flag", int'(und), int'(cur.under));
          in_frame = 1;
        end else in_frame = 0;
        hi_cnt = 0;
        tk_cnt = 0;
      end
      if (in_frame && tick) begin
        tk_cnt++;
        if (pwm) hi_cnt++;
      end
    end
  end

  task automatic wait_req();
    do @(negedge clk); while (!req);
  endtask

  // driver: feed one sample mid-frame, then offer junk while full (R6)
  task automatic feed(input int unsigned v, input int delay);
    repeat (delay) @(negedge clk);
    check("R6 ready before feed", int'(rdy), 1);
    smp <= W'(v);
    vld <= 1'b1;
    @(negedge clk);
    check("R6 ready drops after accept", int'(rdy), 0);
    smp <= W'(v ^ 8'h5A);
    repeat (5) @(negedge clk);
    check("R6 still full, junk ignored", int'(rdy), 0);
    vld <= 1'b0;
    exp_q.push_back('{lvl: v, under: 1'b0});
    last_lvl = v;
  endtask

  task automatic skip();
    exp_q.push_back('{lvl: last_lvl, under: 1'b1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pwm", int'(pwm), 0);
    check("R1 req", int'(req), 0);
    check("R1 underrun", int'(und), 0);
    check("R1 ready", int'(rdy), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pwm after release", int'(pwm), 0);

    // frame 0 plays level 0; feed the sample for frame 1
    feed(128, 20);
    wait_req();
    feed(0, 40);      // R4 zero
    wait_req();
    feed(255, 100);   // R4 full scale
    wait_req();
    feed(1, 200);     // R5 late accept keeps current frame intact
    wait_req();
    skip();           // R7 replay of level 1
    wait_req();
    tick_div = 2;
    feed(37, 30);
    wait_req();
    skip();           // R7 replay of 37 at half rate
    wait_req();
    tick_div = 3;
    feed(200, 300);   // R5 accept deep into a slow frame
    wait_req();
    feed(90, 10);
    wait_req();
    tick_div = 1;
    feed(254, 5);
    wait(frames_done >= 10);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", frames_done, 10);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule